// File: doc/BRIEF.md
# Address-Masked GPIO with Programmable Interrupt Sensing

This block is an eight-pin general-purpose I/O port that sits on a simple APB-style register bus. Each pin can be an input or an output. Software reaches the pin data through a window in which the low address bits act as a per-pin mask. A single bus write can therefore change any subset of the output pins without a read-modify-write sequence, and a read returns only the pins it names.

Every pad input passes through a two-flop synchroniser before any logic sees it. Each pin has its own interrupt detector. Software sets the detector to sense a level (high or low), a single edge (rising or falling), or both edges. Raw detections feed a status register. An enable mask turns that status into a masked view, and the masked bits are ORed into one interrupt line. Software acknowledges latched edge events by writing ones to a clear register, typically the value it just read from masked status.

Top module: `gpio_masked_irq`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: A write to the direction register (word offset 0x400) sets `pin_oe` to the written value on the next cycle. A bit of 1 makes that pin an output. The register reads back what was written.
- R3: A write in the data window (offsets 0x000 to 0x3FC) updates only those output bits n whose address bit n+2 is 1. All other bits of `pin_out` keep their value. `pin_out` changes only on data-window writes.
- R4: A read in the data window returns 0 for every pin whose address bit n+2 is 0. For an unmasked output pin it returns the output register bit, and for an unmasked input pin it returns the pad value after two-flop synchronisation.
- R5: A pin with its sense bit set (offset 0x404, bit = 1) is level-sensitive. Its raw status (offset 0x414) is the synchronised pad when its event bit (offset 0x40C) is 1, and the inverted pad when the event bit is 0. The status is not latched, so a clear write leaves it unchanged while the level persists.
- R6: A pin with its sense bit at 0 and its both-edges bit (offset 0x408) at 0 latches raw status on a rising edge when its event bit is 1, and on a falling edge when its event bit is 0. An edge of the other direction leaves the status unchanged.
- R7: An edge-sensitive pin whose both-edges bit is 1 latches raw status on either edge, whatever its event bit holds.
- R8: A write to the clear register (offset 0x41C) clears the latched edge status of each pin whose written bit is 1 and leaves the other pins untouched. If a new edge arrives in the same cycle as the clear, the new edge wins. The clear register reads as zero.
- R9: Masked status (offset 0x418) reads as raw status AND the enable register (offset 0x410). `irq` is high exactly when masked status is non-zero.
- R10: The sense, both-edges, event and enable registers read back the values written. Any word offset at or above 0x400 with no register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write transfer, 0 = read transfer |
| paddr | input | 12 | Byte address; bits [1:0] ignored |
| pwdata | input | 8 | Write data, one bit per pin |
| prdata | output | 8 | Read data, valid while psel is high |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Output register to the pads |
| pin_oe | output | 8 | Output enable, 1 = pin drives |
| irq | output | 1 | Combined interrupt, high while any masked status bit is set |

## Verification
The checker tests several rules on every cycle. It confirms that `pin_oe` takes the value of a direction write one cycle later, and that a data-window write moves only the pins its address names while `pin_out` otherwise holds still. It checks that latched edge status on an edge-sensitive pin never drops unless a clear is written, that `irq` is never high without both a raw bit and an enable bit, and that the clear register reads zero.

The polarity choices, the both-edges override, level status surviving a clear, the masked data read that mixes output and synchronised input pins, and exact register readback depend on particular pad and register sequences. Only the directed scenarios in the bench show those.

// File: rtl/gpio_mx_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the address-masked GPIO.
// Assumes a 12-bit byte address and word-aligned control registers above the data window.
package gpio_mx_pkg;

    localparam int ADDR_W  = 12;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int MAX_PIN = 8;

    // Word indexes (byte offset >> 2) of the control registers.
    localparam logic [WIDX_W-1:0] IDX_DIR   = 10'h100;
    localparam logic [WIDX_W-1:0] IDX_SENSE = 10'h101;
    localparam logic [WIDX_W-1:0] IDX_BOTH  = 10'h102;
    localparam logic [WIDX_W-1:0] IDX_EVT   = 10'h103;
    localparam logic [WIDX_W-1:0] IDX_EN    = 10'h104;
    localparam logic [WIDX_W-1:0] IDX_RAW   = 10'h105;
    localparam logic [WIDX_W-1:0] IDX_MIS   = 10'h106;
    localparam logic [WIDX_W-1:0] IDX_CLR   = 10'h107;

endpackage

// File: rtl/gpio_mx_sync.sv
`timescale 1ns/1ps
// Module: gpio_mx_sync
// Brings asynchronous pad inputs into the clock domain through a chain of
// STAGES flops per pin. Assumes each pin is independent (no bus coherency).
module gpio_mx_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_sync
);

    logic [NPINS-1:0] stage_q [STAGES];

    // Shift the pad value along the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign pad_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_mx_detect.sv
`timescale 1ns/1ps
// Module: gpio_mx_detect
// Per-pin interrupt sensing. Level pins report the (optionally inverted)
// synchronised input directly. Edge pins latch a flag on the selected edge
// (or either edge) until a clear pulse removes it. A new edge beats a clear
// in the same cycle. Assumes pad_sync is already in the clock domain.
module gpio_mx_detect #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_sync,
    input  logic [NPINS-1:0] sense_lvl,
    input  logic [NPINS-1:0] both_edge,
    input  logic [NPINS-1:0] evt_high,
    input  logic [NPINS-1:0] clr_pulse,
    output logic [NPINS-1:0] raw_stat
);

    logic [NPINS-1:0] prev_q;

    // Remember last cycle's synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pad_sync;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall, hit, lvl_act, flag_q;

        assign rise    = pad_sync[i] & ~prev_q[i];
        assign fall    = ~pad_sync[i] & prev_q[i];
        assign hit     = ~sense_lvl[i] &
                         (both_edge[i] ? (rise | fall)
                                       : (evt_high[i] ? rise : fall));
        assign lvl_act = evt_high[i] ? pad_sync[i] : ~pad_sync[i];

        // Hold an edge event until acknowledged; fresh edge takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (hit)        flag_q <= 1'b1;
            else if (clr_pulse[i]) flag_q <= 1'b0;
        end

        assign raw_stat[i] = sense_lvl[i] ? lvl_act : flag_q;
    end

endmodule

// File: rtl/gpio_mx_regs.sv
`timescale 1ns/1ps
// Module: gpio_mx_regs
// Register file and bus decode. Holds direction, sensing configuration,
// enable mask and output data. Decodes the address-masked data window and
// produces the write-one-to-clear pulse and the combined interrupt.
// Assumes single-cycle access phase writes (psel & penable & pwrite) and
// read data taken combinationally while psel is high.
module gpio_mx_regs
    import gpio_mx_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPINS-1:0]  pwdata,
    output logic [NPINS-1:0]  prdata,
    input  logic [NPINS-1:0]  pad_sync,
    input  logic [NPINS-1:0]  raw_stat,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  evt_q,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  clr_pulse,
    output logic              irq
);

    localparam int MASK_LO = 2;
    localparam int MASK_HI = NPINS + 1;

    logic [WIDX_W-1:0] widx;
    logic              in_window;
    logic [NPINS-1:0]  pin_mask;
    logic              wr_en;
    logic [NPINS-1:0]  pin_view;
    logic [NPINS-1:0]  mis;

    assign widx      = paddr[ADDR_W-1:2];
    assign in_window = (paddr[ADDR_W-1:ADDR_W-2] == 2'b00);
    assign pin_mask  = paddr[MASK_HI:MASK_LO];
    assign wr_en     = psel & penable & pwrite;

    // Configuration registers: plain word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            evt_q   <= '0;
            en_q    <= '0;
        end else if (wr_en && !in_window) begin
            if (widx == IDX_DIR)   dir_q   <= pwdata;
            if (widx == IDX_SENSE) sense_q <= pwdata;
            if (widx == IDX_BOTH)  both_q  <= pwdata;
            if (widx == IDX_EVT)   evt_q   <= pwdata;
            if (widx == IDX_EN)    en_q    <= pwdata;
        end
    end

    // Output data: only pins selected by the address mask take new values.
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_q <= '0;
        else if (wr_en && in_window) out_q <= (out_q & ~pin_mask) | (pwdata & pin_mask);
    end

    // One-cycle acknowledge pulse for the edge flags.
    always_comb begin
        clr_pulse = '0;
        if (wr_en && !in_window && widx == IDX_CLR) clr_pulse = pwdata;
    end

    // Pin view: driven value for outputs, synchronised pad for inputs.
    assign pin_view = (dir_q & out_q) | (~dir_q & pad_sync);
    assign mis      = raw_stat & en_q;

    // Read multiplexer; window reads are masked, unknown offsets give zero.
    always_comb begin
        prdata = '0;
        if (psel) begin
            if (in_window) begin
                prdata = pin_view & pin_mask;
            end else begin
                case (widx)
                    IDX_DIR:   prdata = dir_q;
                    IDX_SENSE: prdata = sense_q;
                    IDX_BOTH:  prdata = both_q;
                    IDX_EVT:   prdata = evt_q;
                    IDX_EN:    prdata = en_q;
                    IDX_RAW:   prdata = raw_stat;
                    IDX_MIS:   prdata = mis;
                    default:   prdata = '0;
                endcase
            end
        end
    end

    // Combined interrupt request.
    assign irq = |mis;

endmodule

// File: rtl/gpio_masked_irq.sv
`timescale 1ns/1ps
// Module: gpio_masked_irq (top)
// Address-masked GPIO port with per-pin level/edge interrupt sensing.
// Assumes NPINS <= 8 so the pin mask fits address bits below the control
// register area, and a synchronous active-low reset.
module gpio_masked_irq
    import gpio_mx_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPINS-1:0]  pwdata,
    output logic [NPINS-1:0]  prdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] raw_stat;
    logic [NPINS-1:0] dir_q, sense_q, both_q, evt_q, en_q, out_q;
    logic [NPINS-1:0] clr_pulse;

    gpio_mx_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pin_in),
        .pad_sync (pad_sync)
    );

    gpio_mx_detect #(.NPINS(NPINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_sync  (pad_sync),
        .sense_lvl (sense_q),
        .both_edge (both_q),
        .evt_high  (evt_q),
        .clr_pulse (clr_pulse),
        .raw_stat  (raw_stat)
    );

    gpio_mx_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pad_sync  (pad_sync),
        .raw_stat  (raw_stat),
        .dir_q     (dir_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .evt_q     (evt_q),
        .en_q      (en_q),
        .out_q     (out_q),
        .clr_pulse (clr_pulse),
        .irq       (irq)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_masked_irq_chk.sv
`timescale 1ns/1ps
// Module: gpio_masked_irq_chk
// Cycle-by-cycle properties of the GPIO port, bound into the top module.
module gpio_masked_irq_chk
    import gpio_mx_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [NPINS-1:0]  pwdata,
    input logic [NPINS-1:0]  prdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  raw_stat,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  sense_q
);

    logic bus_wr, win, wr_dir, wr_clr, rd_clr;

    assign bus_wr = psel && penable && pwrite;
    assign win    = (paddr[ADDR_W-1:ADDR_W-2] == 2'b00);
    assign wr_dir = bus_wr && (paddr[ADDR_W-1:2] == IDX_DIR);
    assign wr_clr = bus_wr && (paddr[ADDR_W-1:2] == IDX_CLR);
    assign rd_clr = psel && !pwrite && (paddr[ADDR_W-1:2] == IDX_CLR);

    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == $past(pwdata)));

    p_window_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win) |=> (((pin_out ^ $past(pin_out)) & ~$past(paddr[NPINS+1:2])) == '0));

    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && win) |=> $stable(pin_out));

    p_edge_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clr |=> ((($past(raw_stat) & ~$past(sense_q)) & ~sense_q & ~raw_stat) == '0));

    p_clear_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |-> (prdata == '0));

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw_stat & en_q) != '0));

endmodule

bind gpio_masked_irq gpio_masked_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .raw_stat (raw_stat),
    .en_q     (en_q),
    .sense_q  (sense_q)
);

// File: tb/test_gpio_masked_irq.sv
`timescale 1ns/1ps
// Directed bench for gpio_masked_irq: one task per scenario.
module test_gpio_masked_irq;

    localparam logic [11:0] A_ALL   = 12'h3FC;
    localparam logic [11:0] A_DIR   = 12'h400;
    localparam logic [11:0] A_SENSE = 12'h404;
    localparam logic [11:0] A_BOTH  = 12'h408;
    localparam logic [11:0] A_EVT   = 12'h40C;
    localparam logic [11:0] A_EN    = 12'h410;
    localparam logic [11:0] A_RAW   = 12'h414;
    localparam logic [11:0] A_MIS   = 12'h418;
    localparam logic [11:0] A_CLR   = 12'h41C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_masked_irq i_gpio_masked_irq (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        bus_rd(A_DIR, d);   chk("R1 dir", d, 8'h00);
        bus_rd(A_SENSE, d); chk("R1 sense", d, 8'h00);
        bus_rd(A_EN, d);    chk("R1 enable", d, 8'h00);
        bus_rd(A_RAW, d);   chk("R1 raw", d, 8'h00);
        bus_rd(A_ALL, d);   chk("R1 data", d, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        bus_wr(A_DIR, 8'hA5);
        chk("R2 pin_oe", pin_oe, 8'hA5);
        bus_rd(A_DIR, d); chk("R2 readback", d, 8'hA5);
    endtask

    task automatic t_masked_write();
        bus_wr(A_DIR, 8'hFF);
        bus_wr(A_ALL, 8'h00);
        chk("R3 clear all", pin_out, 8'h00);
        bus_wr(12'h020, 8'hFF);          // pin 3 only
        chk("R3 single pin", pin_out, 8'h08);
        bus_wr(12'h00C, 8'h02);          // pins 0 and 1
        chk("R3 two pins", pin_out, 8'h0A);
        bus_wr(12'h000, 8'hFF);          // empty mask
        chk("R3 empty mask", pin_out, 8'h0A);
    endtask

    task automatic t_masked_read();
        logic [7:0] d;
        bus_wr(A_DIR, 8'h0F);
        pin_in = 8'hF0;
        settle();
        bus_rd(A_ALL, d);  chk("R4 mixed all", d, 8'hFA);
        bus_rd(12'h0C0, d); chk("R4 input pins 4-5", d, 8'h30);
        bus_rd(12'h004, d); chk("R4 output pin0", d, 8'h00);
        bus_rd(12'h008, d); chk("R4 output pin1", d, 8'h02);
        bus_rd(12'h3C0, d); chk("R4 inputs only", d, 8'hF0);
    endtask

    task automatic t_level();
        logic [7:0] d;
        bus_wr(A_DIR, 8'h00);
        bus_wr(A_SENSE, 8'h03);
        bus_wr(A_EVT, 8'h01);
        bus_wr(A_EN, 8'h03);
        pin_in = 8'h00;
        settle();
        bus_wr(A_CLR, 8'hFF);
        bus_rd(A_RAW, d); chk("R5 low level pin1", d, 8'h02);
        chk("R9 irq on level", {7'b0, irq}, 8'h01);
        pin_in = 8'h01;
        settle();
        bus_rd(A_RAW, d); chk("R5 both levels", d, 8'h03);
        bus_wr(A_CLR, 8'h03);
        bus_rd(A_RAW, d); chk("R5 clear no effect", d, 8'h03);
        pin_in = 8'h02;
        settle();
        bus_rd(A_RAW, d); chk("R5 not latched", d, 8'h00);
        chk("R9 irq low", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_edge_and_clear();
        logic [7:0] d;
        bus_wr(A_SENSE, 8'h00);
        bus_wr(A_BOTH, 8'h00);
        bus_wr(A_EVT, 8'h01);
        bus_wr(A_EN, 8'h00);
        settle();
        bus_wr(A_CLR, 8'hFF);
        bus_rd(A_RAW, d); chk("R6 idle", d, 8'h00);
        pin_in = 8'h03;  settle();
        bus_rd(A_RAW, d); chk("R6 rising pin0", d, 8'h01);
        chk("R9 irq masked off", {7'b0, irq}, 8'h00);
        pin_in = 8'h02;  settle();
        bus_rd(A_RAW, d); chk("R6 latched, wrong edge ignored", d, 8'h01);
        pin_in = 8'h00;  settle();
        bus_rd(A_RAW, d); chk("R6 falling pin1", d, 8'h03);
        bus_wr(A_EN, 8'h02);
        bus_rd(A_MIS, d); chk("R9 masked status", d, 8'h02);
        chk("R9 irq on", {7'b0, irq}, 8'h01);
        bus_wr(A_EN, 8'h00);
        chk("R9 irq off", {7'b0, irq}, 8'h00);
        bus_wr(A_CLR, 8'h01);
        bus_rd(A_RAW, d); chk("R8 clear pin0", d, 8'h02);
        bus_wr(A_CLR, 8'h00);
        bus_rd(A_RAW, d); chk("R8 zero write", d, 8'h02);
        bus_rd(A_CLR, d); chk("R8 clear reads zero", d, 8'h00);
        bus_wr(A_CLR, 8'h02);
        bus_rd(A_RAW, d); chk("R8 clear pin1", d, 8'h00);
    endtask

    task automatic t_both_edges();
        logic [7:0] d;
        bus_wr(A_BOTH, 8'h04);
        bus_rd(A_BOTH, d); chk("R10 both readback", d, 8'h04);
        bus_rd(A_EVT, d);  chk("R10 event readback", d, 8'h01);
        pin_in = 8'h04;  settle();
        bus_rd(A_RAW, d); chk("R7 rising with falling polarity", d, 8'h04);
        bus_wr(A_CLR, 8'h04);
        bus_rd(A_RAW, d); chk("R7 cleared", d, 8'h00);
        pin_in = 8'h00;  settle();
        bus_rd(A_RAW, d); chk("R7 falling", d, 8'h04);
        bus_wr(A_SENSE, 8'h80);
        bus_rd(A_SENSE, d); chk("R10 sense readback", d, 8'h80);
        bus_rd(12'h420, d); chk("R10 unmapped", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_masked_write();
        t_masked_read();
        t_level();
        t_edge_and_clear();
        t_both_edges();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule